// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block sits in the decode stage of a short in-order pipeline that may issue instructions from the same thread back to back. Each cycle it looks at three pipeline positions: the instruction in decode, the instruction one step older (execute), and the instruction two steps older (memory access). From each instruction's class it works out three things: whether the instruction writes a destination register, whether it reads the register file, and whether its result is ready after a single cycle. It then compares the decode instruction's source registers with the destinations of the two older instructions.

When the youngest matching producer has a single-cycle result, the block steers that operand to the forwarding path of the producer's stage. When the youngest matching producer is a two-cycle instruction (multiply, barrel shift, load, accelerator read, special-register read), the block requests a stall. The dependent instruction is loaded again, and writeback for the bubble slot is suppressed. A taken branch without a delay slot, reported at a clock edge, makes the next decode slot a NOP. The datapath multiplexers are outside this block.

The controller is a two-state machine. In state RUN, hazard detection and forwarding are live. In state SHADOW, the decode slot is a squashed NOP. The transition RUN→SHADOW ("squash") fires on a taken branch with no delay slot. The transition SHADOW→RUN ("resume") fires unconditionally after one cycle. Otherwise RUN→RUN ("advance") applies.

Top module: `hzc_hazard_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, with no branch reported, `nop_o` is 0, and with a decode class that reads nothing, `stall_o` and `wb_block_o` are 0 and both selects are 0.
- R2: Classes that never write a register (NOP=0, STORE=5, PUT=7, MTS=9, IMM=10, BCOND=11, BJUMP=12, RET=14) cause neither forwarding nor a stall, whatever their destination field holds. Class codes are ALU=1, MUL=2, BSH=3, LOAD=4, GET=6, MFS=8, BLINK=13. Codes 15 and above behave as NOP.
- R3: A decode instruction of class GET, MFS, IMM or NOP reads no register and never forwards or stalls. When `dec_b_imm` is 1, `dec_rb` is ignored.
- R4: When the execute-stage instruction is a single-cycle writer (ALU or BLINK) and its nonzero destination equals a used source, that operand's select is 1 (execute path).
- R5: When only the memory-stage instruction matches a used source and it is a single-cycle writer, the select is 2 (memory path). Select 0 means the register file.
- R6: When both older instructions match the same source, only the execute-stage instruction decides the outcome (forward or stall).
- R7: When the deciding producer for any used source is a two-cycle class (MUL, BSH, LOAD, GET, MFS) at distance one or two, `stall_o` and `wb_block_o` are 1 and both selects are 0.
- R8: A destination of register 0 never matches, so it causes no forwarding and no stall.
- R9: When `br_taken`=1 and `br_delay`=0 are sampled at a rising edge in state RUN, the next cycle has `nop_o`=1 and `wb_block_o`=1, with `stall_o`=0 and both selects 0. A taken branch with a delay slot, or a branch that is not taken, leaves `nop_o` at 0.
- R10: The squash lasts exactly one cycle. A branch reported during the SHADOW cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_cls | input | 4 | Class code of the instruction in decode |
| dec_ra | input | AW | Source register A of the decode instruction |
| dec_rb | input | AW | Source register B of the decode instruction |
| dec_b_imm | input | 1 | Operand B is an immediate, so `dec_rb` is unused |
| ex_cls | input | 4 | Class code of the instruction one step older |
| ex_rd | input | AW | Destination of the instruction one step older |
| ma_cls | input | 4 | Class code of the instruction two steps older |
| ma_rd | input | AW | Destination of the instruction two steps older |
| br_taken | input | 1 | Branch in execute resolved taken |
| br_delay | input | 1 | That branch has a delay slot |
| fwd_a | output | 2 | Operand A source: 0 register file, 1 execute, 2 memory |
| fwd_b | output | 2 | Operand B source, same coding |
| stall_o | output | 1 | Stall and re-issue the decode instruction |
| wb_block_o | output | 1 | Suppress writeback for the slot entering execute |
| nop_o | output | 1 | Decode slot replaced by a NOP |

## Verification
The assertions assume that class codes arrive as settled values and that `br_taken` and `br_delay` describe the instruction actually held in execute. They also assume the environment honours a stall by presenting a bubble (class NOP) as the next execute-stage instruction. The stimulus keeps within these assumptions. The exhaustive sweep over class triples and register patterns holds the branch inputs low, so the machine stays in RUN. The branch sequences are applied one cycle at a time, with inputs changed only on the falling edge.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
    typedef enum logic [3:0] {
        IC_NOP   = 4'd0,
        IC_ALU   = 4'd1,
        IC_MUL   = 4'd2,
        IC_BSH   = 4'd3,
        IC_LOAD  = 4'd4,
        IC_STORE = 4'd5,
        IC_GET   = 4'd6,
        IC_PUT   = 4'd7,
        IC_MFS   = 4'd8,
        IC_MTS   = 4'd9,
        IC_IMM   = 4'd10,
        IC_BCOND = 4'd11,
        IC_BJUMP = 4'd12,
        IC_BLINK = 4'd13,
        IC_RET   = 4'd14
    } iclass_e;

    typedef enum logic [1:0] {
        FS_RF = 2'd0,
        FS_EX = 2'd1,
        FS_MA = 2'd2
    } fsel_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SHADOW = 1'b1
    } hz_state_e;

    localparam int NUM_POS = 3;
    localparam int NUM_SRC = 2;
endpackage

// File: rtl/hzc_classify.sv
module hzc_classify
    import hzc_pkg::*;
(
    input  logic [3:0] cls,
    output logic       writes,
    output logic       reads,
    output logic       slow
);
    always_comb begin
        writes = 1'b0;
        reads  = 1'b0;
        slow   = 1'b0;
        case (cls)
            IC_ALU:   begin writes = 1'b1; reads = 1'b1; end
            IC_MUL,
            IC_BSH,
            IC_LOAD:  begin writes = 1'b1; reads = 1'b1; slow = 1'b1; end
            IC_GET,
            IC_MFS:   begin writes = 1'b1; slow = 1'b1; end
            IC_BLINK: begin writes = 1'b1; reads = 1'b1; end
            IC_STORE,
            IC_PUT,
            IC_MTS,
            IC_BCOND,
            IC_BJUMP,
            IC_RET:   reads = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/hzc_operand.sv
module hzc_operand
    import hzc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          used,
    input  logic [AW-1:0] src,
    input  logic          ex_wr,
    input  logic          ex_slow,
    input  logic [AW-1:0] ex_rd,
    input  logic          ma_wr,
    input  logic          ma_slow,
    input  logic [AW-1:0] ma_rd,
    output logic [1:0]    sel,
    output logic          haz
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic hit_ex;
    logic hit_ma;

    assign hit_ex = used && ex_wr && (ex_rd != ZERO_REG) && (ex_rd == src);
    assign hit_ma = used && ma_wr && (ma_rd != ZERO_REG) && (ma_rd == src);

    always_comb begin
        sel = FS_RF;
        haz = 1'b0;
        if (hit_ex) begin
            if (ex_slow) haz = 1'b1;
            else         sel = FS_EX;
        end else if (hit_ma) begin
            if (ma_slow) haz = 1'b1;
            else         sel = FS_MA;
        end
    end
endmodule

// File: rtl/hzc_hazard_ctrl.sv
module hzc_hazard_ctrl
    import hzc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    dec_cls,
    input  logic [AW-1:0] dec_ra,
    input  logic [AW-1:0] dec_rb,
    input  logic          dec_b_imm,
    input  logic [3:0]    ex_cls,
    input  logic [AW-1:0] ex_rd,
    input  logic [3:0]    ma_cls,
    input  logic [AW-1:0] ma_rd,
    input  logic          br_taken,
    input  logic          br_delay,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          stall_o,
    output logic          wb_block_o,
    output logic          nop_o
);
    hz_state_e state, state_nx;

    logic [3:0]    pos_cls  [NUM_POS];
    logic          pos_wr   [NUM_POS];
    logic          pos_rd   [NUM_POS];
    logic          pos_slow [NUM_POS];
    logic [AW-1:0] src_reg  [NUM_SRC];
    logic          src_used [NUM_SRC];
    logic [1:0]    src_sel  [NUM_SRC];
    logic [NUM_SRC-1:0] src_haz;
    logic          unused_flags;

    assign pos_cls[0] = dec_cls;
    assign pos_cls[1] = ex_cls;
    assign pos_cls[2] = ma_cls;

    generate
        for (genvar p = 0; p < NUM_POS; p++) begin : g_cls
            hzc_classify u_cls (
                .cls    (pos_cls[p]),
                .writes (pos_wr[p]),
                .reads  (pos_rd[p]),
                .slow   (pos_slow[p])
            );
        end
    endgenerate

    assign unused_flags = ^{pos_wr[0], pos_slow[0], pos_rd[1], pos_rd[2]};

    assign src_reg[0]  = dec_ra;
    assign src_reg[1]  = dec_rb;
    assign src_used[0] = pos_rd[0];
    assign src_used[1] = pos_rd[0] && !dec_b_imm;

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            hzc_operand #(.AW(AW)) u_opr (
                .used    (src_used[s]),
                .src     (src_reg[s]),
                .ex_wr   (pos_wr[1]),
                .ex_slow (pos_slow[1]),
                .ex_rd   (ex_rd),
                .ma_wr   (pos_wr[2]),
                .ma_slow (pos_slow[2]),
                .ma_rd   (ma_rd),
                .sel     (src_sel[s]),
                .haz     (src_haz[s])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (br_taken && !br_delay) state_nx = ST_SHADOW;
            ST_SHADOW: state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        fwd_a      = FS_RF;
        fwd_b      = FS_RF;
        stall_o    = 1'b0;
        wb_block_o = 1'b0;
        nop_o      = 1'b0;
        unique case (state)
            ST_RUN: begin
                stall_o    = |src_haz;
                wb_block_o = |src_haz;
                if (!(|src_haz)) begin
                    fwd_a = src_sel[0];
                    fwd_b = src_sel[1];
                end
            end
            ST_SHADOW: begin
                nop_o      = 1'b1;
                wb_block_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/hzc_hazard_ctrl_chk.sv
module hzc_hazard_ctrl_chk
    import hzc_pkg::*;
#(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    dec_cls,
    input logic [AW-1:0] dec_ra,
    input logic [AW-1:0] dec_rb,
    input logic          dec_b_imm,
    input logic [3:0]    ex_cls,
    input logic [AW-1:0] ex_rd,
    input logic [3:0]    ma_cls,
    input logic [AW-1:0] ma_rd,
    input logic          br_taken,
    input logic          br_delay,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_b,
    input logic          stall_o,
    input logic          wb_block_o,
    input logic          nop_o
);
    function automatic logic c_noread(logic [3:0] c);
        return (c == IC_GET) || (c == IC_MFS) || (c == IC_IMM) || (c == IC_NOP) || (c > IC_RET);
    endfunction

    function automatic logic c_slow(logic [3:0] c);
        return (c == IC_MUL) || (c == IC_BSH) || (c == IC_LOAD) || (c == IC_GET) || (c == IC_MFS);
    endfunction

    logic unused_chk;
    assign unused_chk = ^{dec_rb, dec_b_imm, ma_cls, ma_rd};

    AST_BRANCH_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !br_delay && !nop_o) |=> nop_o); // R9
    AST_NO_SPURIOUS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!nop_o && !(br_taken && !br_delay)) |=> !nop_o); // R9
    AST_SHADOW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        nop_o |=> !nop_o); // R10
    AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        nop_o |-> (!stall_o && wb_block_o && fwd_a == 2'd0 && fwd_b == 2'd0)); // R9
    AST_STALL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (wb_block_o && fwd_a == 2'd0 && fwd_b == 2'd0)); // R7
    AST_NOREAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        c_noread(dec_cls) |-> (!stall_o && fwd_a == 2'd0 && fwd_b == 2'd0)); // R3
    AST_R0_NEVER_A: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_ra == '0) |-> (fwd_a == 2'd0)); // R8
    AST_SLOW_EX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!nop_o && !c_noread(dec_cls) && c_slow(ex_cls) && ex_rd != '0 && ex_rd == dec_ra)
        |-> stall_o); // R7
    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'd3 && fwd_b != 2'd3)); // R4
endmodule

bind hzc_hazard_ctrl hzc_hazard_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_hzc_hazard_ctrl.sv
module sim_hzc_hazard_ctrl;
    import hzc_pkg::*;

    localparam int CLK_P = 10;
    localparam int AW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    dec_cls = 4'd0;
    logic [AW-1:0] dec_ra = '0;
    logic [AW-1:0] dec_rb = '0;
    logic          dec_b_imm = 1'b0;
    logic [3:0]    ex_cls = 4'd0;
    logic [AW-1:0] ex_rd = '0;
    logic [3:0]    ma_cls = 4'd0;
    logic [AW-1:0] ma_rd = '0;
    logic          br_taken = 1'b0;
    logic          br_delay = 1'b0;
    logic [1:0]    fwd_a, fwd_b;
    logic          stall_o, wb_block_o, nop_o;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    hzc_hazard_ctrl #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dec_cls(dec_cls), .dec_ra(dec_ra), .dec_rb(dec_rb), .dec_b_imm(dec_b_imm),
        .ex_cls(ex_cls), .ex_rd(ex_rd), .ma_cls(ma_cls), .ma_rd(ma_rd),
        .br_taken(br_taken), .br_delay(br_delay),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall_o(stall_o),
        .wb_block_o(wb_block_o), .nop_o(nop_o)
    );

    // Class properties taken from R2, R3 and R7
    function automatic bit m_wr(int c);
        return (c == 1) || (c == 2) || (c == 3) || (c == 4) || (c == 6) || (c == 8) || (c == 13);
    endfunction
    function automatic bit m_rd(int c);
        return !((c == 0) || (c == 6) || (c == 8) || (c == 10) || (c >= 15));
    endfunction
    function automatic bit m_slow(int c);
        return (c == 2) || (c == 3) || (c == 4) || (c == 6) || (c == 8);
    endfunction

    task automatic check(string tag, logic [1:0] ea, logic [1:0] eb,
                         logic es, logic ew, logic en);
        n_vec++;
        if (fwd_a !== ea || fwd_b !== eb || stall_o !== es || wb_block_o !== ew || nop_o !== en) begin
            n_bad++;
            $display("FAIL %s: got a=%0d b=%0d st=%0b wb=%0b nop=%0b, exp a=%0d b=%0d st=%0b wb=%0b nop=%0b (cls %0d/%0d/%0d ra=%0d rb=%0d imm=%0b exrd=%0d mard=%0d)",
                     tag, fwd_a, fwd_b, stall_o, wb_block_o, nop_o, ea, eb, es, ew, en,
                     dec_cls, ex_cls, ma_cls, dec_ra, dec_rb, dec_b_imm, ex_rd, ma_rd);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 check("R1", 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 check("R1", 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);

        // Exhaustive class sweep in state RUN (branch inputs low)
        for (int d = 0; d < 15; d++)
        for (int e = 0; e < 15; e++)
        for (int m = 0; m < 15; m++)
        for (int ra = 0; ra < 3; ra++)
        for (int rbi = 0; rbi < 2; rbi++)
        for (int im = 0; im < 2; im++)
        for (int er = 0; er < 3; er++)
        for (int mr = 1; mr < 3; mr++) begin
            logic [1:0] ea, eb;
            logic ha, hb, es;
            int src [2];
            bit use_s [2];
            string tag;
            dec_cls = 4'(d); ex_cls = 4'(e); ma_cls = 4'(m);
            dec_ra = AW'(ra); dec_rb = AW'(2 + rbi); dec_b_imm = im[0];
            ex_rd = AW'(er); ma_rd = AW'(mr);
            src[0] = ra; src[1] = 2 + rbi;
            use_s[0] = m_rd(d); use_s[1] = m_rd(d) && (im == 0);
            ea = 2'd0; eb = 2'd0; ha = 1'b0; hb = 1'b0;
            tag = "R2";
            for (int s = 0; s < 2; s++) begin
                bit he, hm;
                logic [1:0] sv;
                logic hv;
                he = use_s[s] && m_wr(e) && er != 0 && er == src[s];
                hm = use_s[s] && m_wr(m) && mr != 0 && mr == src[s];
                sv = 2'd0; hv = 1'b0;
                if (he) begin
                    if (m_slow(e)) hv = 1'b1; else sv = 2'd1;
                    if (hm) tag = "R6";
                    else if (tag == "R2") tag = hv ? "R7" : "R4";
                end else if (hm) begin
                    if (m_slow(m)) hv = 1'b1; else sv = 2'd2;
                    if (tag == "R2") tag = hv ? "R7" : "R5";
                end
                if (s == 0) begin ea = sv; ha = hv; end
                else        begin eb = sv; hb = hv; end
            end
            es = ha | hb;
            if (es) begin ea = 2'd0; eb = 2'd0; end
            if (!m_rd(d)) tag = "R3";
            else if (tag == "R2" && (er == 0 || ra == 0)) tag = "R8";
            #2 check(tag, ea, eb, es, es, 1'b0);
        end

        // Branch sequences: drive on falling edge, sample after rising edge
        @(negedge clk);
        dec_cls = IC_ALU; dec_ra = 5'd7; dec_rb = 5'd9; dec_b_imm = 1'b0;
        ex_cls = IC_LOAD; ex_rd = 5'd7; ma_cls = IC_ALU; ma_rd = 5'd9;
        br_taken = 1'b1; br_delay = 1'b1;  // delay slot: no squash
        @(posedge clk); #1 check("R9", 2'd0, 2'd0, 1'b1, 1'b1, 1'b0);
        @(negedge clk) br_taken = 1'b0; br_delay = 1'b0;
        @(posedge clk); #1 check("R9", 2'd0, 2'd0, 1'b1, 1'b1, 1'b0);
        @(negedge clk) br_taken = 1'b1; br_delay = 1'b0;  // squash
        @(posedge clk); #1 check("R9", 2'd0, 2'd0, 1'b0, 1'b1, 1'b1);
        @(negedge clk) ex_cls = IC_ALU;  // branch still reported during shadow
        @(posedge clk); #1 check("R10", 2'd1, 2'd2, 1'b0, 1'b0, 1'b0);
        @(negedge clk) br_taken = 1'b0;
        @(posedge clk); #1 check("R10", 2'd1, 2'd2, 1'b0, 1'b0, 1'b0);
        @(negedge clk) br_taken = 1'b1; br_delay = 1'b0; dec_cls = IC_GET;
        @(posedge clk); #1 check("R9", 2'd0, 2'd0, 1'b0, 1'b1, 1'b1);
        @(negedge clk) br_taken = 1'b0;
        @(posedge clk); #1 check("R10", 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule